// File: doc/BRIEF.md
# Watchdog Timer with Initial Window

The block is a down-counting watchdog. Software has to service it ("kick" it) before its count runs out. If the count runs out, the block raises a system reset request. A prescaled tick input paces the count, and the count moves only while the watchdog is enabled.

Two reload values are supplied as inputs. The first is a longer start-up timeout. It is used from reset until software first kicks the watchdog. It is used again after every expiry, because start-up code usually takes longer than one steady-state service interval. The first kick ends this start-up window. From then on, every kick reloads the second, shorter value.

When the count expires, the reset request is held high for a fixed number of clock cycles. Kicks are ignored while the request is high. After the request drops, the watchdog rearms itself in the start-up window.

Top module: `wdog_initwin`

## Requirements
- R1: While `rst_n` is low, and on the first clock edge after it goes high, `rst_req_o` is low and `init_win_o` is high. That first edge loads the count with `init_load_i`.
- R2: The count decrements by one only on a clock edge where `tick_i` is high, `en_i` is high and no kick is present. With `tick_i` low, no reset request ever occurs.
- R3: With the start-up value L (L ≥ 1) loaded, `rst_req_o` rises on the cycle after the L-th qualifying tick, and not before it.
- R4: `rst_req_o` stays high for exactly PULSE_LEN consecutive clock cycles (default 4). `kick_i`, `tick_i` and `en_i` have no effect during this time.
- R5: When the reset request ends, the count is reloaded with `init_load_i`. `init_win_o` is high from the cycle on which `rst_req_o` rises.
- R6: The first kick while enabled clears `init_win_o` on the next cycle and loads `norm_load_i`.
- R7: Every later kick reloads `norm_load_i`. After such a kick, N qualifying ticks are needed before the reset request, where N is the value of `norm_load_i`.
- R8: A kick on the same cycle as the tick that would otherwise expire the count wins. The count is reloaded and no reset request follows.
- R9: While `en_i` is low, the count holds its value and no reset request is raised, whatever `tick_i` and `kick_i` do.
- R10: A loaded value of zero expires on the first qualifying tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Prescaled count enable, one clock wide per tick |
| kick_i | input | 1 | Service strobe from software |
| en_i | input | 1 | Watchdog enable |
| init_load_i | input | CNT_W | Start-up timeout in ticks |
| norm_load_i | input | CNT_W | Steady-state timeout in ticks |
| rst_req_o | output | 1 | System reset request, PULSE_LEN cycles wide |
| init_win_o | output | 1 | High while the start-up window is active |

## Verification
The bench builds the block with CNT_W = 6 and PULSE_LEN = 4. The short count width keeps every expiry within a few dozen cycles. This makes it possible to walk the count through full start-up and steady-state intervals, a kick that coincides with expiry, and a zero reload value. The four-cycle pulse uses the counter variant of the stretcher, so kicks can be injected in the middle of a pulse.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic {
        PH_LOAD = 1'b0,
        PH_RUN  = 1'b1
    } wdog_phase_e;
endpackage

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic busy_o,
    output logic done_o
);
    localparam int PW = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);

    generate
        if (PULSE_LEN <= 1) begin : g_single
            logic hit_d, hit_q;
            always_comb hit_d = fire_i;
            always_ff @(posedge clk) begin
                if (!rst_n) hit_q <= 1'b0;
                else        hit_q <= hit_d;
            end
            assign busy_o = hit_q;
            assign done_o = hit_q;
        end else begin : g_count
            logic [PW-1:0] left_d, left_q;
            always_comb begin
                left_d = left_q;
                if (fire_i)
                    left_d = PW'(PULSE_LEN);
                else if (left_q != '0)
                    left_d = left_q - PW'(1);
            end
            always_ff @(posedge clk) begin
                if (!rst_n) left_q <= '0;
                else        left_q <= left_d;
            end
            assign busy_o = (left_q != '0);
            assign done_o = (left_q == PW'(1));
        end
    endgenerate

    // Pulse starts the cycle after an expiry.
    assert_pulse_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fire_i |=> busy_o);
    // Pulse ends right after its final cycle.
    assert_pulse_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !fire_i) |=> !busy_o);
    // Pulse does not drop before its final cycle.
    assert_pulse_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] init_load_i,
    input  logic [CNT_W-1:0] norm_load_i,
    input  logic             busy_i,
    input  logic             done_i,
    output logic             fire_o,
    output logic             init_win_o
);
    typedef struct packed {
        wdog_phase_e      phase;
        logic             initw;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  fire_d;

    always_comb begin
        st_d   = st_q;
        fire_d = 1'b0;
        if (busy_i) begin
            if (done_i) begin
                st_d.cnt   = init_load_i;
                st_d.initw = 1'b1;
            end
        end else if (st_q.phase == PH_LOAD) begin
            st_d.cnt   = init_load_i;
            st_d.phase = PH_RUN;
        end else if (en_i) begin
            if (kick_i) begin
                st_d.cnt   = norm_load_i;
                st_d.initw = 1'b0;
            end else if (tick_i) begin
                if (st_q.cnt <= CNT_W'(1)) begin
                    fire_d     = 1'b1;
                    st_d.cnt   = '0;
                    st_d.initw = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_LOAD;
            st_q.initw <= 1'b1;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fire_o     = fire_d;
    assign init_win_o = st_q.initw;

    // Disabled: count frozen and no expiry.
    assert_hold_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !busy_i && st_q.phase == PH_RUN) |=> (st_q.cnt == $past(st_q.cnt)));
    assert_no_fire_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !fire_o);
    // Kick reloads the steady value and leaves the start-up window, even on the final tick.
    assert_kick_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && kick_i && !busy_i && st_q.phase == PH_RUN)
            |=> (st_q.cnt == $past(norm_load_i) && !st_q.initw));
    // No tick, no movement.
    assert_tick_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !kick_i && !busy_i && st_q.phase == PH_RUN) |=> $stable(st_q.cnt));
    // End of pulse rearms in the start-up window.
    assert_rearm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |=> (init_win_o && st_q.cnt == $past(init_load_i)));
endmodule

// File: rtl/wdog_initwin.sv
module wdog_initwin #(
    parameter int CNT_W     = 16,
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             kick_i,
    input  logic             en_i,
    input  logic [CNT_W-1:0] init_load_i,
    input  logic [CNT_W-1:0] norm_load_i,
    output logic             rst_req_o,
    output logic             init_win_o
);
    logic fire, busy, done;

    wdog_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .kick_i      (kick_i),
        .en_i        (en_i),
        .init_load_i (init_load_i),
        .norm_load_i (norm_load_i),
        .busy_i      (busy),
        .done_i      (done),
        .fire_o      (fire),
        .init_win_o  (init_win_o)
    );

    wdog_stretch #(.PULSE_LEN(PULSE_LEN)) u_stretch (
        .clk    (clk),
        .rst_n  (rst_n),
        .fire_i (fire),
        .busy_o (busy),
        .done_o (done)
    );

    assign rst_req_o = busy;

    // A rising reset request is always accompanied by the start-up window.
    assert_window_on_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> init_win_o);
    // Request can only rise after a tick.
    assert_rise_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_req_o && !tick_i) |=> !rst_req_o);
endmodule

// File: tb/sim_wdog_initwin.sv
module sim_wdog_initwin;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 6;
    localparam int PL = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0, kick = 1'b0, en = 1'b0;
    logic [CW-1:0] init_ld = 6'd5, norm_ld = 6'd3;
    logic rst_req, init_win;

    int n_chk = 0, n_bad = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_initwin #(.CNT_W(CW), .PULSE_LEN(PL)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .kick_i(kick), .en_i(en),
        .init_load_i(init_ld), .norm_load_i(norm_ld),
        .rst_req_o(rst_req), .init_win_o(init_win)
    );

    // Behavioural reference: remaining ticks, pulse cycles left, window flag.
    int  m_left, m_pulse;
    bit  m_win, m_loaded;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_left = 0; m_pulse = 0; m_win = 1; m_loaded = 0;
        end else if (m_pulse > 0) begin
            m_pulse--;
            if (m_pulse == 0) begin m_left = int'(init_ld); m_win = 1; end
        end else if (!m_loaded) begin
            m_left = int'(init_ld); m_loaded = 1;
        end else if (en && kick) begin
            m_left = int'(norm_ld); m_win = 0;
        end else if (en && tick) begin
            m_left--;
            if (m_left <= 0) begin m_left = 0; m_pulse = PL; m_win = 1; end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_chk++;
            if (rst_req !== (m_pulse > 0) || init_win !== m_win) begin
                n_bad++;
                $display("FAIL R4 model compare cycle %0d: req=%b win=%b expected req=%b win=%b",
                         cyc, rst_req, init_win, m_pulse > 0, m_win);
            end
        end
    end

    task automatic step(input bit t, input bit k, input bit e);
        tick = t; kick = k; en = e;
        @(negedge clk);
        tick = 0; kick = 0;
    endtask

    task automatic chk(input bit act_req, input bit act_win,
                       input bit exp_req, input bit exp_win, input string req);
        n_chk++;
        if (act_req !== exp_req || act_win !== exp_win) begin
            n_bad++;
            $display("FAIL %s: req=%b win=%b expected req=%b win=%b",
                     req, act_req, act_win, exp_req, exp_win);
        end
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        chk(rst_req, init_win, 0, 1, "R1 in reset");
        rst_n = 1;
        step(0, 0, 1);                         // load cycle
        chk(rst_req, init_win, 0, 1, "R1 after load");
        for (int i = 0; i < 10; i++) step(0, 0, 1);
        chk(rst_req, init_win, 0, 1, "R2 no tick no expiry");
        for (int i = 0; i < 4; i++) step(1, 0, 1);
        chk(rst_req, init_win, 0, 1, "R3 four of five ticks");
        step(1, 0, 1);
        chk(rst_req, init_win, 1, 1, "R3 fifth tick expires");
        step(0, 1, 1);
        chk(rst_req, init_win, 1, 1, "R4 pulse 2 kick ignored");
        step(1, 1, 1);
        chk(rst_req, init_win, 1, 1, "R4 pulse 3");
        init_ld = 6'd0;
        step(0, 0, 1);
        chk(rst_req, init_win, 1, 1, "R4 pulse 4");
        step(0, 0, 1);
        chk(rst_req, init_win, 0, 1, "R4 pulse over, R5 window");
        step(1, 0, 1);
        chk(rst_req, init_win, 1, 1, "R10 zero load expires on first tick");
        init_ld = 6'd5;
        for (int i = 0; i < 4; i++) step(0, 0, 1);
        chk(rst_req, init_win, 0, 1, "R5 rearmed after pulse");
        step(0, 1, 1);
        chk(rst_req, init_win, 0, 0, "R6 first kick clears window");
        step(1, 0, 1); step(1, 0, 1);
        chk(rst_req, init_win, 0, 0, "R6 steady value after two ticks");
        step(0, 1, 1);
        step(1, 0, 1); step(1, 0, 1);
        step(1, 1, 1);
        chk(rst_req, init_win, 0, 0, "R8 kick beats final tick");
        for (int i = 0; i < 20; i++) step(1, i[0], 0);
        chk(rst_req, init_win, 0, 0, "R9 disabled no expiry");
        step(1, 0, 1); step(1, 0, 1);
        chk(rst_req, init_win, 0, 0, "R9 count held while off");
        step(1, 0, 1);
        chk(rst_req, init_win, 1, 1, "R7 expiry after steady interval");
        for (int i = 0; i < 4; i++) step(0, 0, 1);
        step(0, 1, 1);
        norm_ld = 6'd7;
        step(0, 1, 1);
        for (int i = 0; i < 6; i++) step(1, 0, 1);
        chk(rst_req, init_win, 0, 0, "R7 new steady value six ticks");
        step(1, 0, 1);
        chk(rst_req, init_win, 1, 1, "R7 new steady value expires");
        for (int i = 0; i < 6; i++) step(0, 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog expired (R1..): run hung");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule